// File: doc/BRIEF.md
# Sample Stream to Frame Assembler

This block turns a qualified sample stream into fixed-size frames. Each clock cycle may carry one sample made of NVAL component values, such as one systematic and two parity values. A valid flag, a start-of-frame flag and an end-of-frame flag qualify the whole sample. Accepted samples are written in arrival order into a buffer that holds OUT_SIZE samples. The buffer drives a wide, flat frame output at all times.

A frame opens on a valid sample that carries the start flag. It closes on a valid sample that carries the end flag. Frames shorter than OUT_SIZE are zero-padded. Samples past OUT_SIZE are dropped. One cycle after the closing sample, a single-cycle frame-valid pulse marks the frame output and the sample count as a finished frame.

The elaboration parameter GROUPED chooses how the frame output is laid out. With GROUPED=0, each sample's components stay together. With GROUPED=1, the output is regrouped so that the same component of every sample sits in one contiguous run.

A small two-state controller handles sequencing:
- ST_IDLE waits for a start.
- ST_COLLECT takes samples.

The transitions are:
- **open**: ST_IDLE to ST_COLLECT, on a valid start sample without the end flag.
- **single**: ST_IDLE to ST_IDLE, on a valid sample that has both the start and end flags.
- **restart**: ST_COLLECT to ST_COLLECT, on a valid start sample without the end flag.
- **close**: ST_COLLECT to ST_IDLE, on a valid end sample.
- **hold**: stay in the current state in every other cycle.

Top module: `stream_frame_assembler`

## Requirements
- R1: While rst is high at a rising edge, the next cycle shows frame_valid=0, frame_len=0 and an all-zero frame_out.
- R2: A cycle with in_valid=0 changes neither frame_out nor the count, whatever the other inputs carry.
- R3: While no frame is open, a valid sample without in_sof is ignored, including one that carries in_eof. It does not alter frame_out, and it produces no frame_valid.
- R4: frame_valid is high for exactly the cycle that follows the edge at which a valid in_eof sample of an open frame is accepted. In that cycle frame_out and frame_len describe the completed frame.
- R5: From a start sample onward, buffer positions that have not been written in the current frame read as zero. A short frame is therefore zero-padded.
- R6: Once OUT_SIZE samples are held, further samples of the same frame are dropped. frame_len saturates at OUT_SIZE.
- R7: frame_len equals the number of samples stored for the current frame.
- R8: Input component c of in_data occupies bits [c*DW +: DW]. With GROUPED=0, component c of stored sample s appears in frame_out at slot s*NVAL+c. Slot k occupies bits [k*DW +: DW].
- R9: With GROUPED=1, component c of stored sample s appears in frame_out at slot c*OUT_SIZE+s.
- R10: A valid in_sof that arrives while a frame is open discards the partial frame. Collection restarts, with that sample as sample 0.
- R11: A valid sample that has both in_sof and in_eof forms a one-sample frame. frame_valid rises in the next cycle with frame_len=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | NVAL*DW | Component values of one sample |
| in_sof | input | 1 | Start-of-frame flag for the sample |
| in_eof | input | 1 | End-of-frame flag for the sample |
| in_valid | input | 1 | Sample qualifier; low means idle |
| frame_out | output | NVAL*OUT_SIZE*DW | Frame buffer in the chosen layout |
| frame_valid | output | 1 | One-cycle pulse marking a finished frame |
| frame_len | output | $clog2(OUT_SIZE+1) | Number of samples stored, qualified by frame_valid |

## Verification
Two events can fall in the same cycle:
- A sample can both open and close a frame.
- The start of the next frame can arrive in the cycle where frame_valid presents the previous one.

The bench drives a start sample immediately after an end sample. It also drives a combined start-and-end sample, and a start inside an open frame. Random frames place starts without gaps at random. Each case is judged by comparing frame_valid, frame_len and frame_out in every cycle with a bench model of the buffer. The model is checked in both output layouts, so the pulse must still show the finished frame while the new one begins overwriting the buffer one edge later.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } sfa_state_e;
endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
    import sfa_pkg::*;
#(
    parameter int OUT_SIZE = 6,
    parameter int CW       = $clog2(OUT_SIZE + 1),
    parameter int IW       = (OUT_SIZE > 1) ? $clog2(OUT_SIZE) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          wr_en,
    output logic          clr,
    output logic [IW-1:0] wr_idx,
    output logic [CW-1:0] cnt,
    output logic          frame_valid
);
    localparam logic [CW-1:0] MAXC = CW'(OUT_SIZE);

    sfa_state_e state_q, state_d;
    logic start, take, room, done;

    assign start  = in_valid & in_sof;
    assign take   = in_valid & (in_sof | (state_q == ST_COLLECT));
    assign room   = (cnt < MAXC);
    assign done   = take & in_eof;
    assign clr    = start;
    assign wr_en  = start | (take & room);
    assign wr_idx = start ? '0 : cnt[IW-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = in_eof ? ST_IDLE : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (in_valid && in_eof)      state_d = ST_IDLE;
                else if (start)              state_d = ST_COLLECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs: sample count and completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= done;
            if (start)             cnt <= CW'(1);
            else if (take && room) cnt <= cnt + CW'(1);
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!frame_valid && cnt == '0 && state_q == ST_IDLE));
    a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAXC);
    a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(in_valid && in_eof));
    a_r4_close_pulses: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COLLECT && in_valid && in_eof) |=> frame_valid);
    a_r11_single_frame: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && in_eof) |=> (frame_valid && cnt == CW'(1)));
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COLLECT && in_valid && in_sof && !in_eof)
        |=> (state_q == ST_COLLECT && cnt == CW'(1)));
    a_r2_idle_count: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt));
endmodule

// File: rtl/sfa_buffer.sv
module sfa_buffer #(
    parameter int DW       = 8,
    parameter int NVAL     = 3,
    parameter int OUT_SIZE = 6,
    parameter int IW       = (OUT_SIZE > 1) ? $clog2(OUT_SIZE) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [IW-1:0]                wr_idx,
    input  logic [NVAL*DW-1:0]           din,
    output logic [OUT_SIZE*NVAL*DW-1:0]  mem
);
    localparam int SW = NVAL * DW;

    for (genvar s = 0; s < OUT_SIZE; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[s*SW +: SW] <= '0;
            end else if (wr_en && wr_idx == IW'(s)) begin
                mem[s*SW +: SW] <= din;
            end else if (clr) begin
                mem[s*SW +: SW] <= '0;
            end
        end
    end

    a_r2_buffer_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !clr) |=> $stable(mem));
    a_r5_clear_tail: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mem[OUT_SIZE*SW-1:SW] == '0) || (OUT_SIZE == 1));
endmodule

// File: rtl/sfa_order.sv
module sfa_order #(
    parameter int DW       = 8,
    parameter int NVAL     = 3,
    parameter int OUT_SIZE = 6,
    parameter bit GROUPED  = 1'b0
) (
    input  logic [OUT_SIZE*NVAL*DW-1:0] mem,
    output logic [OUT_SIZE*NVAL*DW-1:0] frame
);
    for (genvar s = 0; s < OUT_SIZE; s++) begin : g_s
        for (genvar c = 0; c < NVAL; c++) begin : g_c
            localparam int SRC = s * NVAL + c;
            localparam int DST = GROUPED ? (c * OUT_SIZE + s) : SRC;
            assign frame[DST*DW +: DW] = mem[SRC*DW +: DW];
        end
    end
endmodule

// File: rtl/stream_frame_assembler.sv
module stream_frame_assembler #(
    parameter int DW       = 8,
    parameter int NVAL     = 3,
    parameter int OUT_SIZE = 6,
    parameter bit GROUPED  = 1'b0,
    localparam int CW      = $clog2(OUT_SIZE + 1),
    localparam int IW      = (OUT_SIZE > 1) ? $clog2(OUT_SIZE) : 1,
    localparam int FW      = OUT_SIZE * NVAL * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NVAL*DW-1:0] in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic               in_valid,
    output logic [FW-1:0]      frame_out,
    output logic               frame_valid,
    output logic [CW-1:0]      frame_len
);
    logic          wr_en, clr;
    logic [IW-1:0] wr_idx;
    logic [FW-1:0] mem;

    sfa_ctrl #(.OUT_SIZE(OUT_SIZE), .CW(CW), .IW(IW)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .wr_en(wr_en), .clr(clr), .wr_idx(wr_idx),
        .cnt(frame_len), .frame_valid(frame_valid)
    );

    sfa_buffer #(.DW(DW), .NVAL(NVAL), .OUT_SIZE(OUT_SIZE), .IW(IW)) u_buf (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .din(in_data), .mem(mem)
    );

    sfa_order #(.DW(DW), .NVAL(NVAL), .OUT_SIZE(OUT_SIZE), .GROUPED(GROUPED)) u_order (
        .mem(mem), .frame(frame_out)
    );

    a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame_len != '0));
endmodule

// File: tb/stream_frame_assembler_tb.sv
module stream_frame_assembler_tb;
    localparam int DW = 8, NVAL = 3, OUT = 6;
    localparam int CW = $clog2(OUT + 1);
    localparam int FW = OUT * NVAL * DW;

    logic clk = 1'b0, rst = 1'b1;
    logic [NVAL*DW-1:0] in_data = '0;
    logic in_sof = 0, in_eof = 0, in_valid = 0;
    logic [FW-1:0] fo_a, fo_b;
    logic fv_a, fv_b;
    logic [CW-1:0] len_a, len_b;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    stream_frame_assembler #(.DW(DW), .NVAL(NVAL), .OUT_SIZE(OUT), .GROUPED(1'b0)) u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_valid(in_valid), .frame_out(fo_a), .frame_valid(fv_a), .frame_len(len_a));
    stream_frame_assembler #(.DW(DW), .NVAL(NVAL), .OUT_SIZE(OUT), .GROUPED(1'b1)) u_dut_grp (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_valid(in_valid), .frame_out(fo_b), .frame_valid(fv_b), .frame_len(len_b));

    // reference model
    logic [DW-1:0] mb [OUT][NVAL];
    int  m_cnt = 0;
    bit  m_open = 0, m_pend = 0;
    string tag = "R1";

    function automatic logic [FW-1:0] pack(input bit grp);
        logic [FW-1:0] r = '0;
        for (int s = 0; s < OUT; s++)
            for (int c = 0; c < NVAL; c++) begin
                int p = grp ? (c * OUT + s) : (s * NVAL + c);
                r[p*DW +: DW] = mb[s][c];
            end
        return r;
    endfunction

    task automatic chk(input string r, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic check_cycle();
        chk({tag, "/R4 fv"}, FW'(fv_a), FW'(m_pend));
        chk({tag, "/R4 fv grp"}, FW'(fv_b), FW'(m_pend));
        if (m_pend) begin
            chk({tag, "/R7 len"}, FW'(len_a), FW'(m_cnt));
            chk({tag, "/R7 len grp"}, FW'(len_b), FW'(m_cnt));
        end
        chk({tag, "/R8 frame"}, fo_a, pack(1'b0));
        chk({tag, "/R9 frame grp"}, fo_b, pack(1'b1));
    endtask

    task automatic step(input logic v, input logic s, input logic e, input logic [NVAL*DW-1:0] d);
        @(negedge clk);
        check_cycle();
        in_valid = v; in_sof = s; in_eof = e; in_data = d;
        m_pend = 0;
        if (v && s) begin
            for (int i = 0; i < OUT; i++)
                for (int c = 0; c < NVAL; c++) mb[i][c] = '0;
            for (int c = 0; c < NVAL; c++) mb[0][c] = d[c*DW +: DW];
            m_cnt = 1; m_open = !e; m_pend = e;
        end else if (v && m_open) begin
            if (m_cnt < OUT) begin
                for (int c = 0; c < NVAL; c++) mb[m_cnt][c] = d[c*DW +: DW];
                m_cnt++;
            end
            if (e) begin m_open = 0; m_pend = 1; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom);
    endtask

    task automatic frame(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1, i == 0, i == n - 1, $urandom);
            if (gap > 0 && i != n - 1) idle($urandom_range(0, gap));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < OUT; i++)
            for (int c = 0; c < NVAL; c++) mb[i][c] = '0;
        repeat (3) @(negedge clk);
        in_valid = 1; in_sof = 1; in_data = '1;   // held in reset: must be ignored
        @(negedge clk);
        rst = 0; in_valid = 0; in_sof = 0;
        tag = "R1";
        chk("R1 len", FW'(len_a), '0);
        chk("R1 fv", FW'(fv_a), '0);
        chk("R1 frame", fo_a, '0);
        tag = "R5";  frame(3, 2);                 // short frame with idles, R2 R5 R7
        idle(2);
        tag = "R3";
        step(1, 0, 0, 24'hABCDEF); step(1, 0, 1, 24'h123456); idle(1);
        tag = "R6";  frame(9, 1);                 // truncated
        tag = "R6";  frame(OUT, 0);               // exactly full
        tag = "R11"; step(1, 1, 1, 24'h0A0B0C); idle(1);
        tag = "R10"; frame(4, 0); step(1, 1, 0, 24'h111111);   // open then restart
        step(1, 1, 0, 24'h222222); step(1, 0, 0, 24'h333333); step(1, 0, 1, 24'h444444);
        tag = "R4";  frame(2, 0); frame(3, 0); step(1, 1, 1, 24'h555555); frame(1, 0);
        tag = "R2";
        for (int f = 0; f < 300; f++) begin
            int kind = $urandom_range(0, 9);
            if (kind == 0) step(1, 0, $urandom_range(0, 1), $urandom);
            else if (kind == 1) begin
                frame($urandom_range(1, 4), 0);
                step(1, 1, 0, $urandom);
            end
            frame($urandom_range(1, 10), $urandom_range(0, 3));
            if ($urandom_range(0, 1)) idle($urandom_range(0, 3));
        end
        idle(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R4 act=timeout exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule